// File: doc/BRIEF.md
# Programmable Binary Interval Timer

This block is a binary timer built from a chain of counter stages. Each stage advances on a system clock cycle in which the `tick` input is high; in use, `tick` is a clock enable that stands in for a slow oscillator. A two-bit tap code picks which stage drives the output, so the output period is 2^N ticks with N being 8, 10, 13 or 16. One tap code feeds the upper half of the chain straight from the tick rather than from the lower half's carry. That gives a 256-tick period from the top stage.

The output can run as a continuous square wave (recycle) or as a one-shot. In one-shot mode the output flips after half the selected period and then stays there. A master reset clears the chain, and so does a power-on reset input that can be disabled. While the chain is clear, the output sits at a polarity level chosen by `pol_sel`. One-shot operation is re-armed by a master reset or by any change of the mode input. Everything is synchronous to `clk`.

Top module: `prog_timer`

## Requirements
- R1: The tap code is {`sel_a`,`sel_b`}. Code 00 taps stage 13, 01 taps stage 10 and 11 taps stage 16, where stage k is bit k-1 of a binary count of ticks. In recycle mode the output period is 2^N ticks and the output first goes to the active level after 2^(N-1) ticks.
- R2: Code 10 clocks stages 9 to 16 directly from every tick and taps stage 16, which gives a period of 256 ticks and a first active level after 128 ticks.
- R3: With `mrst` high at a clock edge, every stage is cleared at that edge, whatever the count was.
- R4: With `ar_dis` low, `por` high at a clock edge clears the chain exactly as `mrst` does. With `ar_dis` high, `por` is ignored and the count carries on.
- R5: While the chain is clear, `tmr_out` equals `pol_sel`.
- R6: With `recycle` high, `tmr_out` is `pol_sel` XOR the tapped stage, which is a continuous square wave.
- R7: With `recycle` low, `tmr_out` moves to the inverse of `pol_sel` once 2^(N-1) ticks have been counted after a clear. It then holds that level while more ticks arrive, including when the tapped stage wraps back to 0.
- R8: The one-shot hold is released by a master reset, or by a change of `recycle` seen at a clock edge. After release, the output again follows the tapped stage until that stage next goes high.
- R9: The count advances only on clock edges where `tick` is high. A clear wins over a tick on the same edge.
- R10: A change of the tap code does not clear the chain. The output tap moves to the new code at the next tick, not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset request, active high |
| ar_dis | input | 1 | High ignores `por` |
| mrst | input | 1 | Master reset, active high, synchronous |
| tick | input | 1 | Count enable, one count per high cycle |
| sel_a | input | 1 | Tap code, upper bit |
| sel_b | input | 1 | Tap code, lower bit |
| pol_sel | input | 1 | Output level while the chain is clear |
| recycle | input | 1 | 1 selects the square wave, 0 selects the one-shot |
| tmr_out | output | 1 | Timer output |

## Verification
The count, the registered tap code and the one-shot flag all change on the clock edge that samples `tick` or a reset. The output is decoded from those registers and the live `pol_sel`, so each result is due one edge after its stimulus. The bench drives inputs on the falling edge and samples on the falling edge that follows the last counted tick. A run of n ticks is therefore read with exactly n counted. A change of the tap code without a tick is read one idle cycle later, to show that the output has not moved. A mode toggle is held for one edge and the release is read on the falling edge after the second edge.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

   typedef enum logic [1:0] {
      TAP_MID  = 2'b00,
      TAP_LOW  = 2'b01,
      TAP_BYP  = 2'b10,
      TAP_TOP  = 2'b11
   } tap_code_e;

   function automatic tap_code_e to_code(input logic hi_bit, input logic lo_bit);
      return tap_code_e'({hi_bit, lo_bit});
   endfunction

endpackage

// File: rtl/ptmr_chain.sv
module ptmr_chain #(
   parameter int LO_W      = 8,
   parameter int HI_W      = 8,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic            clk,
   input  logic            clr,
   input  logic            tick,
   input  logic            byp,
   output logic [LO_W-1:0] lo_cnt,
   output logic [HI_W-1:0] hi_cnt
);

   logic hi_step;
   logic lo_carry;

   assign lo_carry = &lo_cnt;

   generate
      if (BYPASS_EN) begin : g_byp
         assign hi_step = tick & (byp | lo_carry);
      end else begin : g_nobyp
         logic unused_byp;
         assign unused_byp = byp;
         assign hi_step    = tick & lo_carry;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (clr) begin
         lo_cnt <= '0;
      end else if (tick) begin
         lo_cnt <= lo_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (clr) begin
         hi_cnt <= '0;
      end else if (hi_step) begin
         hi_cnt <= hi_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/ptmr_tap.sv
module ptmr_tap
   import ptmr_pkg::*;
#(
   parameter int LO_W    = 8,
   parameter int HI_W    = 8,
   parameter int STG_MID = 13,
   parameter int STG_LOW = 10,
   parameter int STG_TOP = 16
) (
   input  logic [LO_W+HI_W-1:0] cnt,
   input  tap_code_e            code,
   output logic                 tap
);

   localparam int CNT_W = LO_W + HI_W;

   generate
      if (STG_MID < 1 || STG_MID > CNT_W) begin : g_bad_mid
         $error("STG_MID out of range");
      end
      if (STG_LOW < 1 || STG_LOW > CNT_W) begin : g_bad_low
         $error("STG_LOW out of range");
      end
      if (STG_TOP < 1 || STG_TOP > CNT_W) begin : g_bad_top
         $error("STG_TOP out of range");
      end
   endgenerate

   always_comb begin
      unique case (code)
         TAP_MID: tap = cnt[STG_MID-1];
         TAP_LOW: tap = cnt[STG_LOW-1];
         TAP_BYP: tap = cnt[CNT_W-1];
         TAP_TOP: tap = cnt[STG_TOP-1];
         default: tap = 1'b0;
      endcase
   end

endmodule

// File: rtl/ptmr_shot.sv
module ptmr_shot (
   input  logic clk,
   input  logic clr,
   input  logic mode_in,
   input  logic tap,
   input  logic pol,
   output logic held,
   output logic out
);

   logic mode_q;
   logic mode_chg;

   assign mode_chg = mode_in ^ mode_q;

   always_ff @(posedge clk) begin
      mode_q <= mode_in;
      if (clr || mode_chg) begin
         held <= 1'b0;
      end else begin
         held <= held | tap;
      end
   end

   always_comb begin
      if (mode_in) begin
         out = pol ^ tap;
      end else begin
         out = pol ^ (tap | held);
      end
   end

endmodule

// File: rtl/prog_timer.sv
module prog_timer
   import ptmr_pkg::*;
#(
   parameter int LO_W      = 8,
   parameter int HI_W      = 8,
   parameter int STG_MID   = 13,
   parameter int STG_LOW   = 10,
   parameter int STG_TOP   = 16,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic clk,
   input  logic por,
   input  logic ar_dis,
   input  logic mrst,
   input  logic tick,
   input  logic sel_a,
   input  logic sel_b,
   input  logic pol_sel,
   input  logic recycle,
   output logic tmr_out
);

   localparam int CNT_W = LO_W + HI_W;

   generate
      if (LO_W < 1 || HI_W < 1) begin : g_bad_w
         $error("chain halves must be at least one stage");
      end
   endgenerate

   logic            clr;
   tap_code_e       code_in;
   tap_code_e       code_q;
   logic [LO_W-1:0] lo_cnt;
   logic [HI_W-1:0] hi_cnt;
   logic            tap;
   logic            held;

   assign clr     = mrst | (por & ~ar_dis);
   assign code_in = to_code(sel_a, sel_b);

   always_ff @(posedge clk) begin
      if (clr || tick) begin
         code_q <= code_in;
      end
   end

   ptmr_chain #(
      .LO_W      (LO_W),
      .HI_W      (HI_W),
      .BYPASS_EN (BYPASS_EN)
   ) u_chain (
      .clk    (clk),
      .clr    (clr),
      .tick   (tick),
      .byp    (code_in == TAP_BYP),
      .lo_cnt (lo_cnt),
      .hi_cnt (hi_cnt)
   );

   ptmr_tap #(
      .LO_W    (LO_W),
      .HI_W    (HI_W),
      .STG_MID (STG_MID),
      .STG_LOW (STG_LOW),
      .STG_TOP (STG_TOP)
   ) u_tap (
      .cnt  ({hi_cnt, lo_cnt}),
      .code (code_q),
      .tap  (tap)
   );

   ptmr_shot u_shot (
      .clk     (clk),
      .clr     (clr),
      .mode_in (recycle),
      .tap     (tap),
      .pol     (pol_sel),
      .held    (held),
      .out     (tmr_out)
   );

endmodule

// File: rtl/prog_timer_chk.sv
module prog_timer_chk #(
   parameter int LO_W = 8,
   parameter int HI_W = 8
) (
   input logic            clk,
   input logic            clr,
   input logic            por,
   input logic            ar_dis,
   input logic            mrst,
   input logic            tick,
   input logic            sel_a,
   input logic            sel_b,
   input logic            pol_sel,
   input logic            recycle,
   input logic            tmr_out,
   input logic [LO_W-1:0] lo_cnt,
   input logic [HI_W-1:0] hi_cnt,
   input logic [1:0]      code_q
);

   logic armed = 1'b0;

   always_ff @(posedge clk) begin
      armed <= armed | clr;
   end

   // R3
   clear_all_chk: assert property (@(posedge clk) disable iff (!armed)
      mrst |=> (lo_cnt == '0 && hi_cnt == '0));

   // R4
   por_ignored_chk: assert property (@(posedge clk) disable iff (!armed)
      (por && ar_dis && !mrst && !tick) |=> ($stable(lo_cnt) && $stable(hi_cnt)));

   // R5
   reset_level_chk: assert property (@(posedge clk) disable iff (!armed)
      clr |=> (tmr_out == pol_sel));

   // R9
   tick_gate_chk: assert property (@(posedge clk) disable iff (clr || !armed)
      !tick |=> ($stable(lo_cnt) && $stable(hi_cnt)));

   // R1
   lo_step_chk: assert property (@(posedge clk) disable iff (clr || !armed)
      tick |=> (lo_cnt == $past(lo_cnt) + 1'b1));

   // R2
   byp_step_chk: assert property (@(posedge clk) disable iff (clr || !armed)
      (tick && sel_a && !sel_b) |=> (hi_cnt == $past(hi_cnt) + 1'b1));

   // R10
   code_hold_chk: assert property (@(posedge clk) disable iff (clr || !armed)
      !tick |=> $stable(code_q));

   // R7
   shot_hold_chk: assert property (@(posedge clk) disable iff (clr || !armed)
      (!$past(clr) && !$past(recycle) && !$past(recycle, 2) && !recycle
       && $past(tmr_out != pol_sel) && $stable(pol_sel)) |-> (tmr_out != pol_sel));

endmodule

bind prog_timer prog_timer_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
   .clk     (clk),
   .clr     (clr),
   .por     (por),
   .ar_dis  (ar_dis),
   .mrst    (mrst),
   .tick    (tick),
   .sel_a   (sel_a),
   .sel_b   (sel_b),
   .pol_sel (pol_sel),
   .recycle (recycle),
   .tmr_out (tmr_out),
   .lo_cnt  (lo_cnt),
   .hi_cnt  (hi_cnt),
   .code_q  (code_q)
);

// File: tb/sim_prog_timer.sv
module sim_prog_timer;

   logic clk = 1'b0;
   logic por = 1'b1;
   logic ar_dis = 1'b0;
   logic mrst = 1'b0;
   logic tick = 1'b0;
   logic sel_a = 1'b0;
   logic sel_b = 1'b0;
   logic pol_sel = 1'b0;
   logic recycle = 1'b1;
   logic tmr_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   prog_timer u0 (
      .clk     (clk),
      .por     (por),
      .ar_dis  (ar_dis),
      .mrst    (mrst),
      .tick    (tick),
      .sel_a   (sel_a),
      .sel_b   (sel_b),
      .pol_sel (pol_sel),
      .recycle (recycle),
      .tmr_out (tmr_out)
   );

   typedef struct packed {
      logic [1:0]  code;
      logic        mode;
      logic        pol;
      logic [16:0] ticks;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{2'b00, 1'b1, 1'b0, 17'd4095},
      '{2'b00, 1'b1, 1'b0, 17'd4096},
      '{2'b00, 1'b1, 1'b1, 17'd8192},
      '{2'b00, 1'b0, 1'b0, 17'd8192},
      '{2'b01, 1'b1, 1'b1, 17'd511},
      '{2'b01, 1'b1, 1'b1, 17'd512},
      '{2'b01, 1'b0, 1'b1, 17'd1536},
      '{2'b10, 1'b1, 1'b0, 17'd127},
      '{2'b10, 1'b1, 1'b0, 17'd128},
      '{2'b10, 1'b1, 1'b1, 17'd256},
      '{2'b10, 1'b0, 1'b0, 17'd300},
      '{2'b11, 1'b1, 1'b1, 17'd32768}
   };

   function automatic int stages(input logic [1:0] code);
      case (code)
         2'b00:   return 13;
         2'b01:   return 10;
         2'b10:   return 8;
         default: return 16;
      endcase
   endfunction

   function automatic logic expect_out(input logic [1:0] code, input logic mode,
                                       input logic pol, input int k);
      int  n;
      logic b;
      n = stages(code);
      if (mode) b = ((k >> (n - 1)) & 1) != 0;
      else      b = (k >= (1 << (n - 1)));
      return pol ^ b;
   endfunction

   task automatic chk(input string tag, input logic exp);
      n_chk++;
      if (tmr_out !== exp) begin
         n_bad++;
         $display("FAIL %s: tmr_out got %b expected %b", tag, tmr_out, exp);
      end
   endtask

   task automatic restart(input logic [1:0] code, input logic mode, input logic pol);
      {sel_a, sel_b} = code;
      recycle = mode;
      pol_sel = pol;
      mrst = 1'b1;
      @(negedge clk);
      mrst = 1'b0;
   endtask

   task automatic run(input int n);
      if (n > 0) begin
         tick = 1'b1;
         repeat (n) @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run hung, got timeout expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      // power-on reset with auto reset enabled
      repeat (2) @(negedge clk);
      por = 1'b0;
      @(negedge clk);
      chk("R4 R5 power-on clear, level = pol 0", 1'b0);

      // vector table: R1 R2 R6 R7
      for (int i = 0; i < NV; i++) begin
         restart(VECS[i].code, VECS[i].mode, VECS[i].pol);
         chk("R5 reset level", VECS[i].pol);
         run(int'(VECS[i].ticks));
         chk($sformatf("R1 R2 R6 R7 vector %0d", i),
             expect_out(VECS[i].code, VECS[i].mode, VECS[i].pol, int'(VECS[i].ticks)));
      end

      // R7 hold after wrap, R8 re-arm by mode change
      restart(2'b10, 1'b0, 1'b0);
      run(128);
      chk("R7 one-shot fires at 128", 1'b1);
      run(128);
      chk("R7 one-shot holds past wrap", 1'b1);
      recycle = 1'b1;
      @(negedge clk);
      recycle = 1'b0;
      @(negedge clk);
      chk("R8 mode toggle releases hold", 1'b0);
      run(128);
      chk("R8 re-armed one-shot fires again", 1'b1);
      run(128);
      chk("R7 holds again", 1'b1);

      // R8 re-arm by master reset, R3 clear mid count
      mrst = 1'b1;
      @(negedge clk);
      mrst = 1'b0;
      chk("R3 R8 master reset clears hold", 1'b0);
      run(127);
      chk("R3 count restarted from zero (127)", 1'b0);
      run(1);
      chk("R8 fires after 128 from reset", 1'b1);

      // R4 por ignored when disabled
      restart(2'b10, 1'b1, 1'b0);
      run(128);
      ar_dis = 1'b1;
      por = 1'b1;
      @(negedge clk);
      por = 1'b0;
      chk("R4 por ignored with ar_dis high", 1'b1);
      run(128);
      chk("R4 count kept through ignored por", 1'b0);
      run(128);
      ar_dis = 1'b0;
      por = 1'b1;
      @(negedge clk);
      por = 1'b0;
      chk("R4 por clears with ar_dis low", 1'b0);

      // R9 tick gating and reset priority
      restart(2'b10, 1'b1, 1'b0);
      run(128);
      repeat (300) @(negedge clk);
      chk("R9 no tick no change", 1'b1);
      run(127);
      chk("R9 count intact after idle (255)", 1'b1);
      run(1);
      chk("R9 count wraps at 256", 1'b0);
      run(64);
      tick = 1'b1;
      mrst = 1'b1;
      @(negedge clk);
      mrst = 1'b0;
      tick = 1'b0;
      run(127);
      chk("R9 reset beats tick (127 after)", 1'b0);
      run(1);
      chk("R9 reset beats tick (128 after)", 1'b1);

      // R10 tap change without clear
      restart(2'b00, 1'b1, 1'b0);
      run(4096);
      chk("R10 stage 13 high at 4096", 1'b1);
      {sel_a, sel_b} = 2'b01;
      @(negedge clk);
      chk("R10 tap unchanged before a tick", 1'b1);
      run(1);
      chk("R10 tap moves at tick (stage 10 of 4097)", 1'b0);
      {sel_a, sel_b} = 2'b00;
      run(1);
      chk("R10 count not cleared (stage 13 of 4098)", 1'b1);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule